// File: doc/BRIEF.md
# Flag-setting adder with condition evaluator

This block adds two W-bit operands and a carry-in. It returns the W-bit sum together with a four-bit flag vector: negative, zero, carry and overflow. The flags are computed combinationally for the current operands. They are copied into a flag register only on a clock edge where the set-flags strobe is high. A condition evaluator reads the stored flags and a four-bit condition code and reports whether the condition holds. An instruction can therefore test flags that an earlier operation produced.

To subtract, the caller inverts the second operand and drives the carry-in high. The carry flag then reads one when no borrow occurred, which is when the first operand is greater than or equal to the second as unsigned numbers. The block has no logical-operation flags, no saturation and no multi-cycle arithmetic.

Top module: `nzcv_alu_core`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^W.
- R2: The flag vector holds negative at bit 3, zero at bit 2, carry at bit 1 and overflow at bit 0. Negative is the top bit of `sum`, and zero is set exactly when `sum` is all zeros.
- R3: Carry is set when the exact unsigned total `op_a` + `op_b` + `carry_in` differs from `sum` read as unsigned, that is, when the total is at least 2^W.
- R4: Overflow is set when the exact two's-complement total of `op_a` + `op_b` + `carry_in` differs from `sum` read as signed.
- R5: On a rising clock edge with `set_flags` high and `rst` low, `flags_q` takes the value of `flags_now`.
- R6: On a rising clock edge with `set_flags` low and `rst` low, `flags_q` keeps its value, whatever the operands are.
- R7: A rising clock edge with `rst` high clears `flags_q` to 0000, even when `set_flags` is high.
- R8: Condition bits [3:1] select the base test on the stored flags. The encodings are:
  - 000: zero set
  - 001: carry set
  - 010: negative set
  - 011: overflow set
  - 100: carry set and zero clear
  - 101: negative equals overflow
  - 110: negative equals overflow and zero clear
  - 111: always true
- R9: When condition bit 0 is one, `cond_pass` is the inverse of the base test. The exception is code 1111, which is always true.
- R10: Subtraction with `op_b` inverted and `carry_in` = 1 gives `sum` = `op_a` − `op_b` modulo 2^W. In that case carry is set exactly when `op_a` ≥ `op_b` as unsigned numbers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| set_flags | input | 1 | Load strobe for the flag register |
| cond | input | 4 | Condition code evaluated on the stored flags |
| sum | output | W | Sum modulo 2^W |
| flags_now | output | 4 | Flags of the current addition |
| flags_q | output | 4 | Stored flags |
| cond_pass | output | 1 | High when `cond` holds for `flags_q` |

## Verification
The hardest case to reach is a condition code tested against a flag combination that an earlier operation left in the register. Meanwhile the operands on the ports are trying to produce different flags.

The bench uses a four-bit configuration and sweeps every operand pair with both carry-in values, which is 512 additions. For each addition it loads the flags and then drives the inverted operands with the strobe low. Every one of the sixteen condition codes is checked against the held flags. As a result, each reachable flag pattern is tested with every code while the register must ignore its live input.

// File: rtl/nzcv_pkg.sv
package nzcv_pkg;

    // Flag vector: bit 3 negative, bit 2 zero, bit 1 carry, bit 0 overflow
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam int unsigned FLAG_BITS = $bits(nzcv_t);
    localparam int unsigned COND_BITS = 4;

    // Base test selected by condition bits [3:1]
    typedef enum logic [2:0] {
        SEL_ZERO   = 3'b000,
        SEL_CARRY  = 3'b001,
        SEL_NEG    = 3'b010,
        SEL_OVF    = 3'b011,
        SEL_HIGHER = 3'b100,
        SEL_GE     = 3'b101,
        SEL_GT     = 3'b110,
        SEL_ALL    = 3'b111
    } base_sel_e;

    localparam logic [COND_BITS-1:0] COND_NEVER_INVERT = 4'b1111;

    function automatic logic base_test(nzcv_t f, base_sel_e sel);
        logic r;
        case (sel)
            SEL_ZERO:   r = f.z;
            SEL_CARRY:  r = f.c;
            SEL_NEG:    r = f.n;
            SEL_OVF:    r = f.v;
            SEL_HIGHER: r = f.c & ~f.z;
            SEL_GE:     r = (f.n == f.v);
            SEL_GT:     r = (f.n == f.v) & ~f.z;
            default:    r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic logic cond_holds(nzcv_t f, logic [COND_BITS-1:0] code);
        logic r;
        r = base_test(f, base_sel_e'(code[3:1]));
        if (code[0] && (code != COND_NEVER_INVERT)) begin
            r = ~r;
        end
        return r;
    endfunction

endpackage

// File: rtl/nzcv_adder.sv
module nzcv_adder
    import nzcv_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output nzcv_t        f
);
    localparam int unsigned TOP = W - 1;

    logic [W:0] carry;

    assign carry[0] = cin;

    // Ripple chain so the carry into the top bit is visible for overflow
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign s[i]       = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
    end

    always_comb begin
        f.n = s[TOP];
        f.z = (s == '0);
        f.c = carry[W];
        f.v = carry[W] ^ carry[TOP];
    end

endmodule

// File: rtl/nzcv_flag_store.sv
module nzcv_flag_store
    import nzcv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  nzcv_t d,
    output nzcv_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/nzcv_cond_eval.sv
module nzcv_cond_eval
    import nzcv_pkg::*;
(
    input  nzcv_t                flags,
    input  logic [COND_BITS-1:0] code,
    output logic                 pass
);
    always_comb begin
        pass = cond_holds(flags, code);
    end

endmodule

// File: rtl/nzcv_alu_core.sv
module nzcv_alu_core
    import nzcv_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         carry_in,
    input  logic         set_flags,
    input  logic [3:0]   cond,
    output logic [W-1:0] sum,
    output logic [3:0]   flags_now,
    output logic [3:0]   flags_q,
    output logic         cond_pass
);
    nzcv_t live_f;
    nzcv_t held_f;

    nzcv_adder #(.W(W)) u_add (
        .a   (op_a),
        .b   (op_b),
        .cin (carry_in),
        .s   (sum),
        .f   (live_f)
    );

    nzcv_flag_store u_store (
        .clk  (clk),
        .rst  (rst),
        .load (set_flags),
        .d    (live_f),
        .q    (held_f)
    );

    nzcv_cond_eval u_cond (
        .flags (held_f),
        .code  (cond),
        .pass  (cond_pass)
    );

    assign flags_now = live_f;
    assign flags_q   = held_f;

endmodule

module nzcv_alu_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         set_flags,
    input logic [3:0]   cond,
    input logic [W-1:0] sum,
    input logic [3:0]   flags_now,
    input logic [3:0]   flags_q,
    input logic         cond_pass
);
    // R4: overflow iff like-signed operands give a sum of the other sign
    a_r4_overflow_sign: assert property (@(posedge clk) disable iff (rst)
        flags_now[0] == ((op_a[W-1] == op_b[W-1]) && (sum[W-1] != op_a[W-1])));

    // R5: strobe loads the live flags
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> flags_q == $past(flags_now));

    // R6: no strobe, no change
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable(flags_q));

    // R7: reset clears the stored flags
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> flags_q == 4'b0000);

    // R9: codes 1110 and 1111 always pass
    a_r9_always: assert property (@(posedge clk) disable iff (rst)
        (cond[3:1] == 3'b111) |-> cond_pass);

endmodule

bind nzcv_alu_core nzcv_alu_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .set_flags (set_flags),
    .cond      (cond),
    .sum       (sum),
    .flags_now (flags_now),
    .flags_q   (flags_q),
    .cond_pass (cond_pass)
);

// File: tb/nzcv_alu_core_tb.sv
`timescale 1ns/1ps
module nzcv_alu_core_tb;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic         set_flags = 1'b0;
    logic [3:0]   cond = 4'b0000;
    logic [W-1:0] sum;
    logic [3:0]   flags_now;
    logic [3:0]   flags_q;
    logic         cond_pass;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nzcv_alu_core #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .set_flags(set_flags), .cond(cond), .sum(sum), .flags_now(flags_now),
        .flags_q(flags_q), .cond_pass(cond_pass)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_flags(int a, int b, int ci);
        int u, r, sa, sb, s, n, z, c, v;
        u  = a + b + ci;
        r  = u % M;
        sa = (a >= M/2) ? a - M : a;
        sb = (b >= M/2) ? b - M : b;
        s  = sa + sb + ci;
        n  = (r >= M/2) ? 1 : 0;
        z  = (r == 0) ? 1 : 0;
        c  = (u >= M) ? 1 : 0;
        v  = (s > M/2 - 1 || s < -(M/2)) ? 1 : 0;
        return n*8 + z*4 + c*2 + v;
    endfunction

    function automatic int exp_cond(int f, int code);
        int n, z, c, v, r;
        n = (f >> 3) & 1; z = (f >> 2) & 1; c = (f >> 1) & 1; v = f & 1;
        case (code >> 1)
            0: r = z;
            1: r = c;
            2: r = n;
            3: r = v;
            4: r = (c == 1 && z == 0) ? 1 : 0;
            5: r = (n == v) ? 1 : 0;
            6: r = (n == v && z == 0) ? 1 : 0;
            default: r = 1;
        endcase
        if ((code & 1) == 1 && code != 15) r = 1 - r;
        return r;
    endfunction

    task automatic all_conds(int f);
        for (int k = 0; k < 16; k++) begin
            cond = 4'(k);
            #0.05;
            if ((k >> 1) == 7 || (k & 1) == 1) chk("R9", int'(cond_pass), exp_cond(f, k));
            else chk("R8", int'(cond_pass), exp_cond(f, k));
        end
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ef;
        repeat (3) @(negedge clk);
        #1;
        chk("R7 reset value", int'(flags_q), 0);
        @(negedge clk);
        rst = 1'b0;

        // Exhaustive sweep
        for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    ef = exp_flags(a, b, ci);
                    op_a = W'(a); op_b = W'(b); carry_in = 1'(ci); set_flags = 1'b1;
                    #1;
                    chk("R1 sum", int'(sum), (a + b + ci) % M);
                    chk("R2 N/Z", int'(flags_now[3:2]), ef >> 2);
                    chk("R3 carry", int'(flags_now[1]), (ef >> 1) & 1);
                    chk("R4 overflow", int'(flags_now[0]), ef & 1);
                    @(negedge clk);
                    op_a = ~W'(a); op_b = ~W'(b); carry_in = ~1'(ci); set_flags = 1'b0;
                    #1;
                    chk("R5 load", int'(flags_q), ef);
                    all_conds(ef);
                    @(negedge clk);
                    #1;
                    chk("R6 hold", int'(flags_q), ef);
                    @(negedge clk);
                end
            end
        end

        // R10 subtraction
        op_a = 4'd5; op_b = ~4'd3; carry_in = 1'b1; set_flags = 1'b1;
        #1;
        chk("R10 diff 5-3", int'(sum), 2);
        chk("R10 no borrow", int'(flags_now[1]), 1);
        @(negedge clk);
        op_a = 4'd3; op_b = ~4'd5; carry_in = 1'b1;
        #1;
        chk("R10 diff 3-5", int'(sum), 14);
        chk("R10 borrow", int'(flags_now[1]), 0);
        @(negedge clk);
        op_a = 4'd7; op_b = ~4'd7; carry_in = 1'b1;
        #1;
        chk("R10 equal zero", int'(flags_now), 4'b0110);
        @(negedge clk);

        // R7 reset beats strobe: load nonzero flags first
        op_a = 4'd8; op_b = 4'd8; carry_in = 1'b0; set_flags = 1'b1;
        @(negedge clk);
        #1;
        chk("R5 load before reset", int'(flags_q), exp_flags(8, 8, 0));
        rst = 1'b1;
        @(negedge clk);
        #1;
        chk("R7 reset over strobe", int'(flags_q), 0);
        rst = 1'b0; set_flags = 1'b0;
        @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule